// File: doc/BRIEF.md
# Serial shift chain sniffer

This block listens, without driving anything, to a three-wire serial shift-register bus made of a bus clock, a data line and a strobe line. It keeps its own mirror of the contents of the chained shift registers on that bus. The chain length is given in bytes at run time. Each bus clock pulse moves one new bit into the mirror. The bits already there ripple from byte to byte along the configured length.

A second copy, the snapshot, models the output latches of the chain. The snapshot takes the mirror's contents only when the strobe is high and at least one bit has been shifted since the previous copy. Software or neighbouring logic reads the snapshot one byte at a time through an indexed read port. The three bus wires are asynchronous to the system clock. They pass through two-flop synchronisers, and the system clock must run at least four times faster than the bus clock.

Top module: `chain_snoop`

## Requirements
- R1: Each low-to-high transition of the synchronised bus clock shifts exactly one bit, taken from the synchronised data line. A bus clock held high produces no further shift until it has been low and then goes high again. The mirror updates on the third system clock edge after the bus clock pin goes high.
- R2: The new bit enters bit 0 of byte 0. Bit 7 of byte k moves into bit 0 of byte k+1 for every k below the effective length minus one. Bit 7 of the last byte in the chain is dropped.
- R3: When `len_we_i` is high, the chain length (0 to 255 bytes) is loaded from `len_i`. Bytes at or above the effective length keep their value while shifts occur.
- R4: With an effective length of 0, a bus clock pulse changes no byte and does not set the changed flag, so a later strobe copies nothing.
- R5: A length above DEPTH is clamped to DEPTH. Bits that move past byte DEPTH-1 are lost.
- R6: When the synchronised strobe is high and the changed flag is set, the snapshot is loaded with the mirror as it stood before that edge, and the copy clears the flag. A shift on the same edge sets the flag again, so a strobe that is still high copies the new contents on the next edge.
- R7: Shifts without a qualifying strobe leave the snapshot, and therefore the read data, unchanged.
- R8: `clr_i` zeroes the mirror and the snapshot and clears the changed flag in one cycle. It takes priority over a shift or copy on the same edge.
- R9: `rd_data_o` shows snapshot byte `rd_idx_i` one cycle after the index is presented. An index of DEPTH or above returns 0.
- R10: After reset the mirror, the snapshot, the read data, the changed flag and the length are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Observed bus clock (asynchronous) |
| bus_dat_i | input | 1 | Observed bus data (asynchronous) |
| bus_stb_i | input | 1 | Observed bus strobe (asynchronous) |
| len_we_i | input | 1 | Load chain length |
| len_i | input | 8 | Chain length in bytes |
| clr_i | input | 1 | Synchronous clear of mirror, snapshot and changed flag |
| rd_idx_i | input | 8 | Snapshot byte index |
| rd_data_o | output | 8 | Snapshot byte, registered |

## Verification
A shift and a snapshot copy can fall on the same system clock edge. This happens when the synchronised bus clock rise and a high strobe coincide while the changed flag is already set. The bench provokes it by raising the bus clock and the strobe pins in the same cycle after a shift that has not yet been latched. The snapshot must first take the pre-shift mirror and then, on the following edge, the post-shift mirror. A behavioural model compares the read data with its own result on every clock, and a directed read checks the final byte.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef logic [7:0] cs_byte_t;
  localparam int unsigned CS_LEN_W = 8;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cs_mirror.sv
module cs_mirror
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  shift_i,
  input  logic                  bit_i,
  input  logic [LW-1:0]         len_i,
  output cs_byte_t [DEPTH-1:0]  mem_o
);
  cs_byte_t [DEPTH-1:0] mem_q;
  cs_byte_t [DEPTH-1:0] mem_d;
  logic     [DEPTH-1:0] byte_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic carry_in;
    if (i == 0) begin : g_head
      assign carry_in = bit_i;
    end else begin : g_link
      assign carry_in = mem_q[i-1][7];
    end

    assign byte_en[i] = clr_i || (shift_i && (LW'(i) < len_i));

    always_comb begin
      if (clr_i) mem_d[i] = '0;
      else       mem_d[i] = {mem_q[i][6:0], carry_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mem_q[i] <= '0;
      else if (byte_en[i]) mem_q[i] <= mem_d[i];
    end
  end

  assign mem_o = mem_q;
endmodule

// File: rtl/cs_snapshot.sv
module cs_snapshot
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  copy_i,
  input  cs_byte_t [DEPTH-1:0]  mirror_i,
  input  logic [CS_LEN_W-1:0]   rd_idx_i,
  output cs_byte_t              rd_data_o
);
  cs_byte_t [DEPTH-1:0] snap_q;
  cs_byte_t [DEPTH-1:0] snap_d;
  logic                 snap_en;
  cs_byte_t             rd_d;
  logic                 idx_ok;

  assign snap_en = clr_i || copy_i;

  always_comb begin
    if (clr_i) snap_d = '0;
    else       snap_d = mirror_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  assign idx_ok = (32'(rd_idx_i) < DEPTH);

  always_comb begin
    if (idx_ok) rd_d = snap_q[rd_idx_i[IW-1:0]];
    else        rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= rd_d;
  end
endmodule

// File: rtl/chain_snoop.sv
module chain_snoop
  import cs_pkg::*;
#(
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LW         = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_clk_i,
  input  logic       bus_dat_i,
  input  logic       bus_stb_i,
  input  logic       len_we_i,
  input  logic [7:0] len_i,
  input  logic       clr_i,
  input  logic [7:0] rd_idx_i,
  output logic [7:0] rd_data_o
);
  logic [2:0]            pins_s;
  logic                  bclk_s, bdat_s, bstb_s;
  logic                  bclk_prev_q;
  logic                  bus_rise;
  logic                  shift_en;
  logic                  copy_en;
  logic                  chg_q, chg_d;
  logic [CS_LEN_W-1:0]   len_q;
  logic [LW-1:0]         len_eff;
  cs_byte_t [DEPTH-1:0]  mirror;

  cs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({bus_stb_i, bus_dat_i, bus_clk_i}),
    .sync_o  (pins_s)
  );

  assign bclk_s = pins_s[0];
  assign bdat_s = pins_s[1];
  assign bstb_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        len_q <= '0;
    else if (len_we_i) len_q <= len_i;
  end

  always_comb begin
    if (32'(len_q) > DEPTH) len_eff = LW'(DEPTH);
    else                    len_eff = LW'(len_q);
  end

  assign bus_rise = bclk_s && !bclk_prev_q;
  assign shift_en = bus_rise && (len_eff != '0) && !clr_i;
  assign copy_en  = bstb_s && chg_q && !clr_i;

  always_comb begin
    chg_d = chg_q;
    if (clr_i)         chg_d = 1'b0;
    else if (shift_en) chg_d = 1'b1;
    else if (copy_en)  chg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_d;
  end

  cs_mirror #(.DEPTH(DEPTH)) u_mirror (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .shift_i (shift_en),
    .bit_i   (bdat_s),
    .len_i   (len_eff),
    .mem_o   (mirror)
  );

  cs_snapshot #(.DEPTH(DEPTH)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .copy_i    (copy_en),
    .mirror_i  (mirror),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/chain_snoop_chk.sv
module chain_snoop_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic [7:0]    rd_idx_i,
  input logic [7:0]    rd_data_o,
  input logic          bus_rise,
  input logic          shift_en,
  input logic          copy_en,
  input logic          chg_q,
  input logic [LW-1:0] len_eff,
  input logic [7:0]    mirror0
);
  AST_SINGLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rise |=> !bus_rise); // R1

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_eff == '0 && !clr_i) |=> $stable(mirror0)); // R4

  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(len_eff) <= DEPTH); // R5

  AST_SHIFT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chg_q); // R6

  AST_COPY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_en && !shift_en) |=> !chg_q); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!chg_q && mirror0 == 8'h00)); // R8

  AST_RANGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_idx_i) >= DEPTH) |=> (rd_data_o == 8'h00)); // R9
endmodule

bind chain_snoop chain_snoop_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .bus_rise  (bus_rise),
  .shift_en  (shift_en),
  .copy_en   (copy_en),
  .chg_q     (chg_q),
  .len_eff   (len_eff),
  .mirror0   (mirror[0])
);

// File: tb/chain_snoop_tb_top.sv
module chain_snoop_tb_top;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0, bus_dat = 1'b0, bus_stb = 1'b0;
  logic       len_we = 1'b0;
  logic [7:0] len_v = 8'd0;
  logic       clr = 1'b0;
  logic [7:0] rd_idx = 8'd0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chain_snoop #(.DEPTH(DEPTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_clk_i (bus_clk),
    .bus_dat_i (bus_dat),
    .bus_stb_i (bus_stb),
    .len_we_i  (len_we),
    .len_i     (len_v),
    .clr_i     (clr),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  // Behavioural reference model
  int c1, c2, c3, d1, d2, s1, s2;
  int m_len, m_chg, exp_rd;
  int mir[DEPTH];
  int snp[DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0; s1 = 0; s2 = 0;
      m_len = 0; m_chg = 0; exp_rd = 0;
      for (int i = 0; i < DEPTH; i++) begin mir[i] = 0; snp[i] = 0; end
    end else begin
      int eff;
      bit rise, cp;
      exp_rd = (rd_idx < DEPTH) ? snp[rd_idx] : 0;
      eff  = (m_len > DEPTH) ? DEPTH : m_len;
      rise = (c2 == 1) && (c3 == 0);
      cp   = (s2 == 1) && (m_chg == 1);
      if (clr) begin
        for (int i = 0; i < DEPTH; i++) begin mir[i] = 0; snp[i] = 0; end
        m_chg = 0;
      end else begin
        if (cp) begin
          for (int i = 0; i < DEPTH; i++) snp[i] = mir[i];
          m_chg = 0;
        end
        if (rise && eff > 0) begin
          for (int i = eff - 1; i > 0; i--) mir[i] = ((mir[i] << 1) | (mir[i-1] >> 7)) & 255;
          mir[0] = ((mir[0] << 1) | d2) & 255;
          m_chg = 1;
        end
      end
      if (len_we) m_len = len_v;
      c3 = c2; c2 = c1; c1 = bus_clk;
      d2 = d1; d1 = bus_dat;
      s2 = s1; s1 = bus_stb;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== 8'(exp_rd)) begin
        errors++;
        $display("FAIL R9 model compare idx %0d: actual %0h expected %0h", rd_idx, rd_data, exp_rd);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input int idx, input int exp, input string tag);
    @(negedge clk) rd_idx = 8'(idx);
    @(negedge clk);
    check(tag, int'(rd_data), exp);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk) bus_dat = b;
    repeat (2) @(negedge clk);
    bus_clk = 1'b1;
    repeat (4) @(negedge clk);
    bus_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input int v);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
  endtask

  task automatic strobe();
    @(negedge clk) bus_stb = 1'b1;
    repeat (4) @(negedge clk);
    bus_stb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_len(input int n);
    @(negedge clk) begin len_we = 1'b1; len_v = 8'(n); end
    @(negedge clk) len_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd_chk(0, 0, "R10 reset byte0");
    rd_chk(31, 0, "R10 reset byte31");

    // R2, R7: shift without strobe, then latch
    set_len(2);
    send_byte(8'hC3); send_byte(8'h5A);
    rd_chk(0, 0, "R7 no strobe byte0");
    strobe();
    rd_chk(0, 8'h5A, "R2 byte0");
    rd_chk(1, 8'hC3, "R2 byte1 carry");

    // R3: bytes above length untouched
    do_clear();
    send_byte(8'h12); send_byte(8'h34);
    set_len(1);
    send_byte(8'hFF);
    strobe();
    rd_chk(0, 8'hFF, "R3 byte0 shifted");
    rd_chk(1, 8'h12, "R3 byte1 kept");

    // R6: strobe held high follows each shift
    do_clear();
    @(negedge clk) bus_stb = 1'b1;
    send_bit(1); rd_chk(0, 1, "R6 held strobe 1");
    send_bit(0); rd_chk(0, 2, "R6 held strobe 2");
    send_bit(1); rd_chk(0, 5, "R6 held strobe 3");
    @(negedge clk) bus_stb = 1'b0;

    // R6: shift and copy on the same edge
    do_clear();
    send_bit(1);
    @(negedge clk) bus_dat = 1'b0;
    repeat (2) @(negedge clk);
    bus_clk = 1'b1; bus_stb = 1'b1;
    repeat (4) @(negedge clk);
    bus_clk = 1'b0; bus_stb = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk(0, 2, "R6 same-edge shift and copy");

    // R4: zero length
    do_clear();
    set_len(0);
    for (int k = 0; k < 8; k++) send_bit(1);
    strobe();
    set_len(1);
    strobe();
    rd_chk(0, 0, "R4 zero length no shift");
    send_bit(1);
    strobe();
    rd_chk(0, 1, "R4 mirror empty before");

    // R1: long high pulse is one shift
    do_clear();
    @(negedge clk) bus_dat = 1'b1;
    repeat (2) @(negedge clk);
    bus_clk = 1'b1;
    repeat (30) @(negedge clk);
    bus_clk = 1'b0;
    repeat (4) @(negedge clk);
    strobe();
    rd_chk(0, 1, "R1 one shift per pulse");

    // R8: clear
    do_clear();
    rd_chk(0, 0, "R8 clear snapshot");

    // R5: clamp
    set_len(200);
    for (int b = 0; b <= DEPTH; b++) send_byte(b);
    strobe();
    rd_chk(0, DEPTH, "R5 byte0");
    rd_chk(5, DEPTH - 5, "R5 byte5");
    rd_chk(DEPTH - 1, 1, "R5 last byte");

    // R9: out-of-range index
    rd_chk(40, 0, "R9 index 40");
    rd_chk(255, 0, "R9 index 255");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule